// File: doc/BRIEF.md
# Real-Time Vector Compare Engine

This block checks a 32-channel captured response against an expected vector on every test cycle that the cycle-valid strobe marks. A mask, supplied with each cycle, removes channels from that cycle's comparison. A cycle fails when any channel that is not masked differs from its expected value.

Each failing cycle is written into a 1024-entry, 64-bit record memory, in the order the failures occur. An entry holds the vector address and the captured word. Two counters run alongside the log. One counts failing cycles. The other adds up failing channel bits.

The engine halts the test when any enabled stop condition fires:
- the failing-cycle count reaches a limit;
- the failing-bit total reaches a number;
- the captured word equals a chosen value;
- the vector address equals a chosen value.

Once halted, it ignores further cycles until it is re-armed. The record memory is read through a registered port. It can be read while the test runs or after it stops.

Top module: `vec_compare_engine`

## Requirements
- R1: On an accepted cycle (cycleValid high, not stopped, no armPulse), the mismatch is (capData ^ expData) & ~maskBits. When it is nonzero, failCycles rises by one (saturating) and failBits rises by its population count (saturating at 32 bits). Counters change on the clock edge that samples the cycle.
- R2: A channel whose maskBits bit is 1 never causes a failure, whatever its data and expected values.
- R3: The k-th failing cycle since arm is stored at record index k-1 as {vecAddr in bits 63:32, capData in bits 31:0}, and recCount gives the number of stored entries. rdData returns the entry at rdAddr one clock after rdAddr is sampled.
- R4: Once 1024 entries are stored, later failures are still counted but not written. recCount stays at 1024 and overflow goes to 1.
- R5: With stopEnable bit 0 set, a failing cycle that brings failCycles to at least cycleLimit stops the engine. The limit is 1 to 1024.
- R6: With stopEnable bit 1 set, a failing cycle that brings failBits to at least bitLimit stops the engine.
- R7: With stopEnable bit 2 set, an accepted cycle whose capData equals dataMatchVal stops the engine, whether or not that cycle fails.
- R8: With stopEnable bit 3 set, an accepted cycle whose vecAddr equals addrMatchVal stops the engine. A condition whose enable bit is 0 never stops it.
- R9: stopped goes high after the edge that samples the triggering cycle and stays high until armPulse. That triggering cycle is itself counted and recorded. stopCause latches the conditions that fired, using the stopEnable bit positions, and is zero while not stopped.
- R10: While stopped, cycleValid has no effect on the counters, recCount or the record memory.
- R11: armPulse clears stopped, stopCause, failCycles, failBits, recCount and overflow in one cycle, and a cycleValid on that same cycle is ignored. Record contents are kept.
- R12: After reset, every status output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cycleValid | input | 1 | Marks a test cycle to compare |
| capData | input | 32 | Captured response |
| expData | input | 32 | Expected response |
| maskBits | input | 32 | Per-channel exclusion, 1 = masked |
| vecAddr | input | 32 | Vector address (program counter) of the cycle |
| armPulse | input | 1 | Synchronous clear and re-arm |
| stopEnable | input | 4 | Stop mode enables: 0 cycle count, 1 bit count, 2 data, 3 address |
| cycleLimit | input | 11 | Failing-cycle stop limit |
| bitLimit | input | 32 | Failing-bit stop limit |
| dataMatchVal | input | 32 | Captured word that stops the test |
| addrMatchVal | input | 32 | Address that stops the test |
| rdAddr | input | 10 | Record memory read index |
| rdData | output | 64 | Record entry, one cycle latency |
| stopped | output | 1 | Test halted |
| stopCause | output | 4 | Conditions that caused the halt |
| failCycles | output | 11 | Failing cycles since arm |
| failBits | output | 32 | Failing channel bits since arm |
| recCount | output | 11 | Entries stored since arm |
| overflow | output | 1 | A failure was dropped because the log was full |

## Verification
Most internal faults reach the ports within one clock. A wrong mask or compare term shifts failCycles and failBits right after the faulty cycle. A wrong write pointer shows up when entries are read back, at the wrong index or with the fields swapped. A stop condition that fires late or early appears as a one-cycle shift in stopped. That shift also shows as an extra or missing count, because cycles after the stop are ignored. A fault in the full-log handling stays hidden until the 1025th failure, so the directed tests fill the log past its end.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic accept;   // compare and account this cycle
    logic clearAll; // arm: zero counters and flags
  } ctlStrobes_t;

  // Raw per-cycle conditions from datapath to control
  typedef struct packed {
    logic addrHit;
    logic dataHit;
    logic bitHit;
    logic cycHit;
  } hitFlags_t;

endpackage

// File: rtl/vcmp_datapath.sv
module vcmp_datapath
  import vcmp_pkg::*;
#(
  parameter int CH_W   = 32,
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 1024,
  parameter int BITS_W = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctlStrobes_t              strobes,
  input  logic [CH_W-1:0]          capData,
  input  logic [CH_W-1:0]          expData,
  input  logic [CH_W-1:0]          maskBits,
  input  logic [ADDR_W-1:0]        vecAddr,
  input  logic [CNT_W-1:0]         cycleLimit,
  input  logic [BITS_W-1:0]        bitLimit,
  input  logic [CH_W-1:0]          dataMatchVal,
  input  logic [ADDR_W-1:0]        addrMatchVal,
  input  logic [IDX_W-1:0]         rdAddr,
  output logic [ADDR_W+CH_W-1:0]   rdData,
  output hitFlags_t                hits,
  output logic [CNT_W-1:0]         failCycles,
  output logic [BITS_W-1:0]        failBits,
  output logic [CNT_W-1:0]         recCount,
  output logic                     overflow
);

  localparam int PC_W = $clog2(CH_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [CH_W-1:0]          mismatch;
  logic                     isFail;
  logic [PC_W-1:0]          popCnt;
  logic [CNT_W-1:0]         cycNext;
  logic [BITS_W:0]          bitSum;
  logic [BITS_W-1:0]        bitsNext;
  logic                     logFull;
  logic [ADDR_W+CH_W-1:0]   recMem [DEPTH];

  assign mismatch = (capData ^ expData) & ~maskBits;
  assign isFail   = |mismatch;
  assign logFull  = (recCount == FULL);

  always_comb begin
    popCnt = '0;
    for (int i = 0; i < CH_W; i++) popCnt = popCnt + PC_W'(mismatch[i]);
  end

  assign cycNext  = (&failCycles) ? failCycles : failCycles + 1'b1;
  assign bitSum   = {1'b0, failBits} + (BITS_W + 1)'(popCnt);
  assign bitsNext = bitSum[BITS_W] ? '1 : bitSum[BITS_W-1:0];

  assign hits.cycHit  = isFail && (cycNext >= cycleLimit);
  assign hits.bitHit  = isFail && (bitsNext >= bitLimit);
  assign hits.dataHit = (capData == dataMatchVal);
  assign hits.addrHit = (vecAddr == addrMatchVal);

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clearAll) begin
      failCycles <= '0;
      failBits   <= '0;
      recCount   <= '0;
      overflow   <= 1'b0;
    end else if (strobes.accept && isFail) begin
      failCycles <= cycNext;
      failBits   <= bitsNext;
      if (logFull) overflow <= 1'b1;
      else         recCount <= recCount + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.accept && isFail && !logFull)
      recMem[recCount[IDX_W-1:0]] <= {vecAddr, capData};
    rdData <= recMem[rdAddr];
  end

  // R2: a cycle with no unmasked difference leaves the counters alone
  a_r2_masked_no_count: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.accept && !strobes.clearAll && ((capData ^ expData) & ~maskBits) == '0)
      |=> ($stable(failCycles) && $stable(recCount)));

  // R4: the log never holds more than its depth
  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    recCount <= FULL);

  // R4: overflow only rises when the log was already full
  a_r4_overflow_when_full: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> ($past(recCount) == FULL));

  // R10: without accept or clear, no counter moves
  a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.accept && !strobes.clearAll)
      |=> ($stable(failCycles) && $stable(failBits) && $stable(recCount)));

endmodule

// File: rtl/vcmp_control.sv
module vcmp_control
  import vcmp_pkg::*;
#(
  parameter int N_MODES = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cycleValid,
  input  logic               armPulse,
  input  logic [N_MODES-1:0] stopEnable,
  input  hitFlags_t          hits,
  output ctlStrobes_t        strobes,
  output logic               stopped,
  output logic [N_MODES-1:0] stopCause
);

  logic [N_MODES-1:0] trig;

  assign strobes.clearAll = armPulse;
  assign strobes.accept   = cycleValid && !stopped && !armPulse;

  assign trig = stopEnable & N_MODES'({hits.addrHit, hits.dataHit, hits.bitHit, hits.cycHit});

  always_ff @(posedge clk) begin
    if (!rstN || armPulse) begin
      stopped   <= 1'b0;
      stopCause <= '0;
    end else if (strobes.accept && (|trig)) begin
      stopped   <= 1'b1;
      stopCause <= trig;
    end
  end

  // R9: stop is sticky until armed
  a_r9_stop_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (stopped && !armPulse) |=> (stopped && $stable(stopCause)));

  // R9: a cause is reported exactly when stopped
  a_r9_cause_matches: assert property (@(posedge clk) disable iff (!rstN)
    stopped == (stopCause != '0));

  // R11: arm always releases the stop
  a_r11_arm_clears: assert property (@(posedge clk) disable iff (!rstN)
    armPulse |=> (!stopped && stopCause == '0));

  // R8: only enabled conditions appear as a cause
  a_r8_cause_enabled: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stopped) |-> ((stopCause & ~$past(stopEnable)) == '0));

endmodule

// File: rtl/vec_compare_engine.sv
module vec_compare_engine
  import vcmp_pkg::*;
#(
  parameter int CH_W   = 32,
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 1024,
  parameter int BITS_W = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cycleValid,
  input  logic [CH_W-1:0]        capData,
  input  logic [CH_W-1:0]        expData,
  input  logic [CH_W-1:0]        maskBits,
  input  logic [ADDR_W-1:0]      vecAddr,
  input  logic                   armPulse,
  input  logic [3:0]             stopEnable,
  input  logic [CNT_W-1:0]       cycleLimit,
  input  logic [BITS_W-1:0]      bitLimit,
  input  logic [CH_W-1:0]        dataMatchVal,
  input  logic [ADDR_W-1:0]      addrMatchVal,
  input  logic [IDX_W-1:0]       rdAddr,
  output logic [ADDR_W+CH_W-1:0] rdData,
  output logic                   stopped,
  output logic [3:0]             stopCause,
  output logic [CNT_W-1:0]       failCycles,
  output logic [BITS_W-1:0]      failBits,
  output logic [CNT_W-1:0]       recCount,
  output logic                   overflow
);

  ctlStrobes_t strobes;
  hitFlags_t   hits;

  vcmp_control #(.N_MODES(4)) i_control (
    .clk(clk), .rstN(rstN), .cycleValid(cycleValid), .armPulse(armPulse),
    .stopEnable(stopEnable), .hits(hits), .strobes(strobes),
    .stopped(stopped), .stopCause(stopCause)
  );

  vcmp_datapath #(.CH_W(CH_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH), .BITS_W(BITS_W)) i_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .capData(capData), .expData(expData), .maskBits(maskBits), .vecAddr(vecAddr),
    .cycleLimit(cycleLimit), .bitLimit(bitLimit),
    .dataMatchVal(dataMatchVal), .addrMatchVal(addrMatchVal),
    .rdAddr(rdAddr), .rdData(rdData), .hits(hits),
    .failCycles(failCycles), .failBits(failBits),
    .recCount(recCount), .overflow(overflow)
  );

endmodule

// File: tb/test_vec_compare_engine.sv
module test_vec_compare_engine;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cycleValid = 1'b0;
  logic [31:0] capData = '0, expData = '0, maskBits = '0, vecAddr = '0;
  logic        armPulse = 1'b0;
  logic [3:0]  stopEnable = '0;
  logic [10:0] cycleLimit = '0;
  logic [31:0] bitLimit = '0, dataMatchVal = '0, addrMatchVal = '0;
  logic [9:0]  rdAddr = '0;
  logic [63:0] rdData;
  logic        stopped;
  logic [3:0]  stopCause;
  logic [10:0] failCycles;
  logic [31:0] failBits;
  logic [10:0] recCount;
  logic        overflow;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vec_compare_engine i_vec_compare_engine (
    .clk(clk), .rstN(rstN), .cycleValid(cycleValid), .capData(capData),
    .expData(expData), .maskBits(maskBits), .vecAddr(vecAddr), .armPulse(armPulse),
    .stopEnable(stopEnable), .cycleLimit(cycleLimit), .bitLimit(bitLimit),
    .dataMatchVal(dataMatchVal), .addrMatchVal(addrMatchVal), .rdAddr(rdAddr),
    .rdData(rdData), .stopped(stopped), .stopCause(stopCause),
    .failCycles(failCycles), .failBits(failBits), .recCount(recCount),
    .overflow(overflow)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one valid cycle; returns at the next falling edge, after the sampling edge
  task automatic drive(input logic [31:0] c, input logic [31:0] e,
                       input logic [31:0] m, input logic [31:0] a);
    @(negedge clk);
    cycleValid = 1'b1; capData = c; expData = e; maskBits = m; vecAddr = a;
    @(negedge clk);
    cycleValid = 1'b0;
  endtask

  task automatic arm();
    @(negedge clk);
    armPulse = 1'b1;
    @(negedge clk);
    armPulse = 1'b0;
  endtask

  task automatic readRec(input logic [9:0] idx, output logic [63:0] val);
    @(negedge clk);
    rdAddr = idx;
    @(negedge clk);
    val = rdData;
  endtask

  task automatic testReset();
    check("R12 stopped", 64'(stopped), 64'd0);
    check("R12 cause", 64'(stopCause), 64'd0);
    check("R12 failCycles", 64'(failCycles), 64'd0);
    check("R12 failBits", 64'(failBits), 64'd0);
    check("R12 recCount", 64'(recCount), 64'd0);
    check("R12 overflow", 64'(overflow), 64'd0);
  endtask

  task automatic testCompareAndMask();
    logic [63:0] v;
    stopEnable = 4'b0000;
    arm();
    drive(32'h0000_00AA, 32'h0000_00AA, 32'h0, 32'h0F);
    check("R1 match no fail", 64'(failCycles), 64'd0);
    drive(32'h0000_00FF, 32'h0000_00F8, 32'h0, 32'h10);
    check("R1 failCycles", 64'(failCycles), 64'd1);
    check("R1 failBits popcount", 64'(failBits), 64'd3);
    drive(32'h0000_00F0, 32'h0, 32'h0000_00F0, 32'h20);
    check("R2 fully masked", 64'(failCycles), 64'd1);
    drive(32'h0000_001F, 32'h0, 32'h0000_000F, 32'h11);
    check("R2 partly masked cycles", 64'(failCycles), 64'd2);
    check("R2 partly masked bits", 64'(failBits), 64'd4);
    check("R3 recCount", 64'(recCount), 64'd2);
    readRec(10'd0, v);
    check("R3 entry 0", v, {32'h10, 32'h0000_00FF});
    readRec(10'd1, v);
    check("R3 entry 1", v, {32'h11, 32'h0000_001F});
  endtask

  task automatic testCycleStop();
    stopEnable = 4'b0001; cycleLimit = 11'd3;
    arm();
    check("R11 arm cleared counts", 64'(failCycles), 64'd0);
    drive(32'h1, 32'h0, 32'h0, 32'h100);
    drive(32'h2, 32'h0, 32'h0, 32'h101);
    check("R5 not yet stopped", 64'(stopped), 64'd0);
    drive(32'h3, 32'h0, 32'h0, 32'h102);
    check("R5 stopped at limit", 64'(stopped), 64'd1);
    check("R9 cause cycle", 64'(stopCause), 64'h1);
    check("R9 trigger recorded", 64'(recCount), 64'd3);
    drive(32'h4, 32'h0, 32'h0, 32'h103);
    drive(32'h5, 32'h0, 32'h0, 32'h104);
    check("R10 cycles ignored", 64'(failCycles), 64'd3);
    check("R10 no record", 64'(recCount), 64'd3);
    check("R9 still stopped", 64'(stopped), 64'd1);
    // arm with a valid cycle on the same edge
    @(negedge clk);
    armPulse = 1'b1; cycleValid = 1'b1; capData = 32'hF; expData = 32'h0;
    @(negedge clk);
    armPulse = 1'b0; cycleValid = 1'b0;
    check("R11 stop cleared", 64'(stopped), 64'd0);
    check("R11 cause cleared", 64'(stopCause), 64'd0);
    check("R11 same-cycle valid ignored", 64'(failCycles), 64'd0);
    check("R11 recCount cleared", 64'(recCount), 64'd0);
  endtask

  task automatic testBitStop();
    stopEnable = 4'b0010; bitLimit = 32'd10;
    arm();
    drive(32'h0, 32'hF, 32'h0, 32'h1);
    drive(32'h0, 32'hF0, 32'h0, 32'h2);
    check("R6 below limit", 64'(stopped), 64'd0);
    check("R6 bits 8", 64'(failBits), 64'd8);
    drive(32'h0, 32'hF00, 32'h0, 32'h3);
    check("R6 stopped", 64'(stopped), 64'd1);
    check("R6 cause bit", 64'(stopCause), 64'h2);
    check("R6 bits 12", 64'(failBits), 64'd12);
  endtask

  task automatic testDataStop();
    stopEnable = 4'b0100; dataMatchVal = 32'hCAFE_0000;
    arm();
    drive(32'h1234, 32'h1234, 32'h0, 32'h5);
    check("R7 no stop on other data", 64'(stopped), 64'd0);
    drive(32'hCAFE_0000, 32'hCAFE_0000, 32'h0, 32'h6);
    check("R7 stopped on data", 64'(stopped), 64'd1);
    check("R7 cause data", 64'(stopCause), 64'h4);
    check("R7 passing cycle not counted", 64'(failCycles), 64'd0);
  endtask

  task automatic testAddrStop();
    stopEnable = 4'b1000; addrMatchVal = 32'h40;
    arm();
    drive(32'hCAFE_0000, 32'hCAFE_0000, 32'h0, 32'h3F);
    check("R8 disabled data mode no stop", 64'(stopped), 64'd0);
    drive(32'h0, 32'h0, 32'h0, 32'h40);
    check("R8 stopped on addr", 64'(stopped), 64'd1);
    check("R8 cause addr", 64'(stopCause), 64'h8);
  endtask

  task automatic testOverflow();
    logic [63:0] v;
    stopEnable = 4'b0000;
    arm();
    for (int i = 0; i < 1030; i++)
      drive(32'(i), ~32'(i), 32'h0, 32'h1000 + 32'(i));
    check("R4 recCount capped", 64'(recCount), 64'd1024);
    check("R4 overflow set", 64'(overflow), 64'd1);
    check("R4 still counted", 64'(failCycles), 64'd1030);
    check("R1 bits accumulated", 64'(failBits), 64'd32960);
    readRec(10'd1023, v);
    check("R4 last entry", v, {32'h1000 + 32'd1023, 32'd1023});
    readRec(10'd0, v);
    check("R3 first entry kept", v, {32'h1000, 32'd0});
    arm();
    check("R11 overflow cleared", 64'(overflow), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testCompareAndMask();
    testCycleStop();
    testBitStop();
    testDataStop();
    testAddrStop();
    testOverflow();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule